// File: doc/BRIEF.md
# BCD Calendar Counter with Alarm

This block keeps the time of day and a running day number for a low-power timekeeping domain. A one-second strobe, produced elsewhere from a 32.768 kHz crystal divider, advances a seconds, minutes and hours chain held in packed BCD. The hours chain carries into a 15-bit binary day number. Software reads and writes every field through a byte-wide register port. Each field has its own address, and the day number is split into a low byte and a high byte.

A set of alarm registers holds a minute, an hour and a day number. Each of these fields has its own enable bit, and only the enabled fields take part in the match. When the time rolls onto a minute boundary that matches all enabled fields, a sticky alarm flag sets. The flag drives an interrupt request when the interrupt enable bit is set.

After each accepted second, a busy bit stays high for a short fixed window while the counters settle. Software polls this bit before it touches a time or alarm register. The block ignores writes that arrive during that window.

Top module: `cal_calendar`

## Requirements
- R1: After a synchronous reset every time, day, alarm and control register reads 0x00 and `alarm_irq` is 0.
- R2: Bit 0 of the control byte (address 0x14) is the run bit. A strobe on `sec_tick` while it is 0 changes no counter.
- R3: Seconds (0x15) and minutes (0x16) count in BCD. Each steps from 0x59 to 0x00 and carries one into the next field.
- R4: Hours (0x17) step from 0x23 to 0x00 and add one to the binary day number. The day number is low byte 0x18 and high byte 0x19, of which bits 6:0 hold day bits 14:8. The day number wraps from 0x7FFF to 0x0000.
- R5: Read data appears on `rd_data` after the rising edge that samples `reg_addr`. An unmapped address reads 0x00. Bit 7 of the day high byte and bit 7 of the alarm day high byte always read 0. The alarm fields are at 0x1A (minute), 0x1B (hour), 0x1C (day low) and 0x1D (day high).
- R6: Control bit 7 is the busy bit and is read-only. It reads 1 for exactly the two clock cycles that follow an accepted second, and 0 otherwise.
- R7: A write is ignored when it is presented while busy is 1, or in the same cycle as an accepted second.
- R8: The alarm flag is control bit 2. It sets in the cycle after an accepted second when seconds equal 0x00 and every enabled alarm field equals the time. The enable bits are minute bit 3, hour bit 4 and day bit 5. With no field enabled the flag never sets.
- R9: Writing a control byte with bit 2 set clears the alarm flag. Writing it with bit 2 clear leaves the flag as it was.
- R10: `alarm_irq` equals the alarm flag AND the interrupt enable (control bit 1), delayed by one register stage.
- R11: A field whose enable bit is 0 does not affect the match, whatever its alarm value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| reg_addr | input | 6 | Register address |
| reg_wr | input | 1 | Write strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| alarm_irq | output | 1 | Registered alarm interrupt request |

## Verification
Assertions check on every cycle the following properties:
- Each BCD field wraps to zero from its limit, and the day number wraps from all ones.
- A stopped calendar holds its seconds.
- Busy rises after every accepted second.
- A write to seconds during busy leaves them untouched.
- The flag cannot set with all enables clear, and it clears on a one-write.
- The interrupt only rises behind a set flag.

The bench scenarios show the full multi-field carry from 23:59:59 into the day number, the exact two-cycle shape of the busy bit seen through the read port, and the read-back layout of the day bytes. They also show that a match fires once per matching minute and not on later seconds, and that disabled alarm fields are really left out.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int ADDR_W = 6;
  localparam int DAY_W  = 15;
  localparam int NFIELD = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 6'h14;
  localparam logic [ADDR_W-1:0] A_SEC   = 6'h15;
  localparam logic [ADDR_W-1:0] A_MIN   = 6'h16;
  localparam logic [ADDR_W-1:0] A_HOUR  = 6'h17;
  localparam logic [ADDR_W-1:0] A_DLO   = 6'h18;
  localparam logic [ADDR_W-1:0] A_DHI   = 6'h19;
  localparam logic [ADDR_W-1:0] A_AMIN  = 6'h1A;
  localparam logic [ADDR_W-1:0] A_AHOUR = 6'h1B;
  localparam logic [ADDR_W-1:0] A_ADLO  = 6'h1C;
  localparam logic [ADDR_W-1:0] A_ADHI  = 6'h1D;

  localparam int B_RUN  = 0;
  localparam int B_IE   = 1;
  localparam int B_FLAG = 2;
  localparam int B_MEN  = 3;
  localparam int B_HEN  = 4;
  localparam int B_DEN  = 5;
  localparam int B_BUSY = 7;

  // field index 0 = seconds, 1 = minutes, 2 = hours
  function automatic logic [7:0] field_limit(input int idx);
    return (idx == 2) ? 8'h23 : 8'h59;
  endfunction

  function automatic logic [7:0] bcd_step(input logic [7:0] v);
    if (v[3:0] >= 4'd9) return {v[7:4] + 4'd1, 4'd0};
    else                return {v[7:4], v[3:0] + 4'd1};
  endfunction
endpackage

// File: rtl/cal_bcd_field.sv
module cal_bcd_field #(
  parameter logic [7:0] MAXV = 8'h59
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       inc,
  input  logic       ld,
  input  logic [7:0] ld_val,
  output logic [7:0] val,
  output logic       carry
);
  import cal_pkg::*;

  logic [7:0] val_q;

  assign carry = inc && (val_q == MAXV);
  assign val   = val_q;

  always_ff @(posedge clk) begin
    if (rst)       val_q <= 8'h00;
    else if (ld)   val_q <= ld_val;
    else if (inc)  val_q <= carry ? 8'h00 : bcd_step(val_q);
  end

  AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld && val_q == MAXV) |=> (val_q == 8'h00)); // R3
endmodule

// File: rtl/cal_day_count.sv
module cal_day_count #(
  parameter int DW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          ld_lo,
  input  logic          ld_hi,
  input  logic [7:0]    ld_val,
  output logic [DW-1:0] day
);
  localparam int HI_W = DW - 8;

  logic [DW-1:0] day_q;
  assign day = day_q;

  always_ff @(posedge clk) begin
    if (rst)        day_q <= '0;
    else if (ld_lo) day_q[7:0] <= ld_val;
    else if (ld_hi) day_q[DW-1:8] <= ld_val[HI_W-1:0];
    else if (inc)   day_q <= day_q + 1'b1;
  end

  AST_DAY_WRAP: assert property (@(posedge clk) disable iff (rst)
    (inc && !ld_lo && !ld_hi && (&day_q)) |=> (day_q == '0)); // R4
endmodule

// File: rtl/cal_clock_core.sv
module cal_clock_core
  import cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [NFIELD-1:0] ld_field,
  input  logic             ld_dlo,
  input  logic             ld_dhi,
  input  logic [7:0]       ld_val,
  output logic [7:0]       sec,
  output logic [7:0]       min,
  output logic [7:0]       hour,
  output logic [DAY_W-1:0] day
);
  logic [NFIELD:0] chain;
  logic [7:0]      fval [NFIELD];

  assign chain[0] = step;

  for (genvar i = 0; i < NFIELD; i++) begin : g_field
    cal_bcd_field #(.MAXV(field_limit(i))) u_field (
      .clk    (clk),
      .rst    (rst),
      .inc    (chain[i]),
      .ld     (ld_field[i]),
      .ld_val (ld_val),
      .val    (fval[i]),
      .carry  (chain[i+1])
    );
  end

  cal_day_count #(.DW(DAY_W)) u_day (
    .clk    (clk),
    .rst    (rst),
    .inc    (chain[NFIELD]),
    .ld_lo  (ld_dlo),
    .ld_hi  (ld_dhi),
    .ld_val (ld_val),
    .day    (day)
  );

  assign sec  = fval[0];
  assign min  = fval[1];
  assign hour = fval[2];
endmodule

// File: rtl/cal_alarm.sv
module cal_alarm
  import cal_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ld_min,
  input  logic             ld_hour,
  input  logic             ld_dlo,
  input  logic             ld_dhi,
  input  logic [7:0]       ld_val,
  input  logic             en_min,
  input  logic             en_hour,
  input  logic             en_day,
  input  logic [7:0]       t_sec,
  input  logic [7:0]       t_min,
  input  logic [7:0]       t_hour,
  input  logic [DAY_W-1:0] t_day,
  output logic [7:0]       a_min,
  output logic [7:0]       a_hour,
  output logic [DAY_W-1:0] a_day,
  output logic             hit
);
  localparam int HI_W = DAY_W - 8;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_min  <= 8'h00;
      a_hour <= 8'h00;
      a_day  <= '0;
    end else begin
      if (ld_min)  a_min  <= ld_val;
      if (ld_hour) a_hour <= ld_val;
      if (ld_dlo)  a_day[7:0] <= ld_val;
      if (ld_dhi)  a_day[DAY_W-1:8] <= ld_val[HI_W-1:0];
    end
  end

  logic any_en, m_ok, h_ok, d_ok;
  assign any_en = en_min | en_hour | en_day;
  assign m_ok   = !en_min  || (t_min  == a_min);
  assign h_ok   = !en_hour || (t_hour == a_hour);
  assign d_ok   = !en_day  || (t_day  == a_day);
  assign hit    = any_en && m_ok && h_ok && d_ok && (t_sec == 8'h00);
endmodule

// File: rtl/cal_calendar.sv
module cal_calendar
  import cal_pkg::*;
#(
  parameter int BUSY_CYC = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sec_tick,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic [7:0]        wr_data,
  output logic [7:0]        rd_data,
  output logic              alarm_irq
);
  localparam int BCW = $clog2(BUSY_CYC + 1);

  logic           run_q, ie_q, flag_q, men_q, hen_q, den_q;
  logic [BCW-1:0] busy_cnt;
  logic           busy, step, stepped_q, wr_ok;
  logic           hit;

  logic [7:0]       sec, min, hour, a_min, a_hour;
  logic [DAY_W-1:0] day, a_day;

  assign busy  = (busy_cnt != '0);
  assign step  = sec_tick && run_q;
  assign wr_ok = reg_wr && !busy && !step;

  logic w_ctrl, w_sec, w_min, w_hour, w_dlo, w_dhi;
  logic w_amin, w_ahour, w_adlo, w_adhi;
  assign w_ctrl  = wr_ok && (reg_addr == A_CTRL);
  assign w_sec   = wr_ok && (reg_addr == A_SEC);
  assign w_min   = wr_ok && (reg_addr == A_MIN);
  assign w_hour  = wr_ok && (reg_addr == A_HOUR);
  assign w_dlo   = wr_ok && (reg_addr == A_DLO);
  assign w_dhi   = wr_ok && (reg_addr == A_DHI);
  assign w_amin  = wr_ok && (reg_addr == A_AMIN);
  assign w_ahour = wr_ok && (reg_addr == A_AHOUR);
  assign w_adlo  = wr_ok && (reg_addr == A_ADLO);
  assign w_adhi  = wr_ok && (reg_addr == A_ADHI);

  cal_clock_core u_core (
    .clk      (clk),
    .rst      (rst),
    .step     (step),
    .ld_field ({w_hour, w_min, w_sec}),
    .ld_dlo   (w_dlo),
    .ld_dhi   (w_dhi),
    .ld_val   (wr_data),
    .sec      (sec),
    .min      (min),
    .hour     (hour),
    .day      (day)
  );

  cal_alarm u_alarm (
    .clk     (clk),
    .rst     (rst),
    .ld_min  (w_amin),
    .ld_hour (w_ahour),
    .ld_dlo  (w_adlo),
    .ld_dhi  (w_adhi),
    .ld_val  (wr_data),
    .en_min  (men_q),
    .en_hour (hen_q),
    .en_day  (den_q),
    .t_sec   (sec),
    .t_min   (min),
    .t_hour  (hour),
    .t_day   (day),
    .a_min   (a_min),
    .a_hour  (a_hour),
    .a_day   (a_day),
    .hit     (hit)
  );

  // settle window and control byte
  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt  <= '0;
      stepped_q <= 1'b0;
      run_q <= 1'b0; ie_q <= 1'b0; flag_q <= 1'b0;
      men_q <= 1'b0; hen_q <= 1'b0; den_q <= 1'b0;
      alarm_irq <= 1'b0;
    end else begin
      stepped_q <= step;
      if (step)      busy_cnt <= BCW'(BUSY_CYC);
      else if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (w_ctrl) begin
        run_q <= wr_data[B_RUN];
        ie_q  <= wr_data[B_IE];
        men_q <= wr_data[B_MEN];
        hen_q <= wr_data[B_HEN];
        den_q <= wr_data[B_DEN];
        if (wr_data[B_FLAG]) flag_q <= 1'b0;
      end
      if (stepped_q && hit) flag_q <= 1'b1;
      alarm_irq <= flag_q && ie_q;
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) rd_data <= 8'h00;
    else begin
      case (reg_addr)
        A_CTRL:  rd_data <= {busy, 1'b0, den_q, hen_q, men_q, flag_q, ie_q, run_q};
        A_SEC:   rd_data <= sec;
        A_MIN:   rd_data <= min;
        A_HOUR:  rd_data <= hour;
        A_DLO:   rd_data <= day[7:0];
        A_DHI:   rd_data <= 8'(day[DAY_W-1:8]);
        A_AMIN:  rd_data <= a_min;
        A_AHOUR: rd_data <= a_hour;
        A_ADLO:  rd_data <= a_day[7:0];
        A_ADHI:  rd_data <= 8'(a_day[DAY_W-1:8]);
        default: rd_data <= 8'h00;
      endcase
    end
  end

  AST_BUSY_ON_STEP: assert property (@(posedge clk) disable iff (rst)
    step |=> busy); // R6
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_ok) |=> $stable(sec)); // R2
  AST_BUSY_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && busy && !step && reg_addr == A_SEC) |=> $stable(sec)); // R7
  AST_NO_ENABLE_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && !men_q && !hen_q && !den_q) |=> !flag_q); // R8
  AST_FLAG_W1C: assert property (@(posedge clk) disable iff (rst)
    (w_ctrl && wr_data[B_FLAG]) |=> !flag_q); // R9
  AST_IRQ_BEHIND_FLAG: assert property (@(posedge clk) disable iff (rst)
    $rose(alarm_irq) |-> $past(flag_q)); // R10
endmodule

// File: tb/cal_calendar_bench.sv
module cal_calendar_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sec_tick = 1'b0;
  logic [5:0] reg_addr = '0;
  logic       reg_wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       alarm_irq;

  int errs = 0;
  int checks = 0;
  bit done = 0;

  always #10 clk = ~clk; // 50 MHz

  cal_calendar u_cal_calendar (
    .clk(clk), .rst(rst), .sec_tick(sec_tick), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .wr_data(wr_data), .rd_data(rd_data), .alarm_irq(alarm_irq)
  );

  typedef struct {
    bit         is_irq;
    logic [7:0] exp;
    string      tag;
  } exp_t;
  exp_t sb[$];

  // monitor: compares one expected item per clock, after the edge settles
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        logic [7:0] act;
        e = sb.pop_front();
        act = e.is_irq ? {7'd0, alarm_irq} : rd_data;
        checks++;
        if (act !== e.exp) begin
          errs++;
          $display("FAIL %s: actual=%02h expected=%02h", e.tag, act, e.exp);
        end
      end
    end
  end

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        errs++; checks++;
        $display("FAIL watchdog: actual=hung expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; wr_data = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [7:0] e, input string tag);
    @(negedge clk);
    reg_addr = a;
    sb.push_back('{0, e, tag});
  endtask

  task automatic chk_irq(input logic v, input string tag);
    @(negedge clk);
    sb.push_back('{1, {7'd0, v}, tag});
  endtask

  task automatic tick();
    @(negedge clk);
    sec_tick = 1'b1;
    @(negedge clk);
    sec_tick = 1'b0;
    idle(3);
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
    wr(6'h17, h); wr(6'h16, m); wr(6'h15, s);
  endtask

  initial begin
    idle(3);
    @(negedge clk) rst = 1'b0;

    // R1 reset state
    rd(6'h15, 8'h00, "R1 sec");
    rd(6'h16, 8'h00, "R1 min");
    rd(6'h17, 8'h00, "R1 hour");
    rd(6'h18, 8'h00, "R1 day lo");
    rd(6'h19, 8'h00, "R1 day hi");
    rd(6'h1A, 8'h00, "R1 alarm min");
    rd(6'h14, 8'h00, "R1 ctrl");
    chk_irq(1'b0, "R1 irq");
    rd(6'h00, 8'h00, "R5 unmapped");

    // R2 stopped calendar ignores ticks
    wr(6'h15, 8'h58);
    tick();
    rd(6'h15, 8'h58, "R2 stopped");

    // R3 seconds and minutes carry
    wr(6'h14, 8'h01);
    tick();
    rd(6'h15, 8'h59, "R3 sec step");
    tick();
    rd(6'h15, 8'h00, "R3 sec wrap");
    rd(6'h16, 8'h01, "R3 min carry");
    set_time(8'h05, 8'h59, 8'h59);
    tick();
    rd(6'h17, 8'h06, "R3 hour carry");
    rd(6'h16, 8'h00, "R3 min wrap");

    // R4 day carry and wrap, R5 high-byte layout
    set_time(8'h23, 8'h59, 8'h59);
    wr(6'h18, 8'hFF); wr(6'h19, 8'h00);
    tick();
    rd(6'h17, 8'h00, "R4 hour wrap");
    rd(6'h18, 8'h00, "R4 day lo");
    rd(6'h19, 8'h01, "R4 day hi carry");
    set_time(8'h23, 8'h59, 8'h59);
    wr(6'h18, 8'hFF); wr(6'h19, 8'hFF);
    rd(6'h19, 8'h7F, "R5 day hi bit7");
    tick();
    rd(6'h18, 8'h00, "R4 day wrap lo");
    rd(6'h19, 8'h00, "R4 day wrap hi");
    wr(6'h1D, 8'hFF);
    rd(6'h1D, 8'h7F, "R5 alarm day hi bit7");

    // R6 busy window seen on the read port
    @(negedge clk);
    reg_addr = 6'h14; sec_tick = 1'b1;
    sb.push_back('{0, 8'h01, "R6 busy before"});
    @(negedge clk);
    sec_tick = 1'b0;
    sb.push_back('{0, 8'h81, "R6 busy cycle 1"});
    @(negedge clk);
    sb.push_back('{0, 8'h81, "R6 busy cycle 2"});
    @(negedge clk);
    sb.push_back('{0, 8'h01, "R6 busy over"});
    idle(2);

    // R7 writes during tick and busy dropped (sec now 01)
    @(negedge clk);
    sec_tick = 1'b1; reg_wr = 1'b1; reg_addr = 6'h15; wr_data = 8'h22;
    @(negedge clk);
    sec_tick = 1'b0; wr_data = 8'h33;
    @(negedge clk);
    wr_data = 8'h44;
    @(negedge clk);
    reg_wr = 1'b0;
    idle(2);
    rd(6'h15, 8'h02, "R7 writes dropped");

    // R8/R10 full alarm match
    wr(6'h1A, 8'h10); wr(6'h1B, 8'h02); wr(6'h1C, 8'h05); wr(6'h1D, 8'h00);
    set_time(8'h02, 8'h09, 8'h59);
    wr(6'h18, 8'h05); wr(6'h19, 8'h00);
    wr(6'h14, 8'h3B);
    tick();
    rd(6'h14, 8'h3F, "R8 flag set");
    chk_irq(1'b1, "R10 irq on");
    // R9 zero write keeps, one write clears
    wr(6'h14, 8'h3B);
    rd(6'h14, 8'h3F, "R9 zero keeps flag");
    wr(6'h14, 8'h3F);
    rd(6'h14, 8'h3B, "R9 one clears flag");
    chk_irq(1'b0, "R10 irq off");
    // R8 non-zero second in matching minute does not fire
    tick();
    rd(6'h14, 8'h3B, "R8 only at second zero");

    // R8 no enables: never fires
    wr(6'h14, 8'h03);
    set_time(8'h02, 8'h09, 8'h59);
    tick();
    rd(6'h14, 8'h03, "R8 no enable no flag");
    chk_irq(1'b0, "R8 no irq");

    // R11 hour and day disabled while they mismatch; R10 gated by enable
    wr(6'h14, 8'h09);
    set_time(8'h07, 8'h09, 8'h59);
    tick();
    rd(6'h14, 8'h0D, "R11 minute-only match");
    chk_irq(1'b0, "R10 irq gated");
    wr(6'h14, 8'h0B);
    idle(1);
    chk_irq(1'b1, "R10 irq after enable");

    idle(4);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule